// File: doc/BRIEF.md
# X/Y Memory Bus Break Comparator

This block watches bus traffic and raises a break-match pulse when one programmed condition is met. The core it serves has one wide internal bus and two narrow data-memory buses, called X and Y. Two control bits choose the source. With the X/Y enable clear, the block compares the full-width internal-bus address, and optionally the data, against programmable values. With the X/Y enable set, it watches either the X bus or the Y bus, never both.

In X/Y mode, the 32-bit address and data compare registers, and their masks, are split in two. The upper half holds the X-bus condition and the lower half holds the Y-bus condition. A mask bit of 1 removes that bit from the compare.

Each candidate cycle must also pass qualifiers for bus master, access kind, direction and operand size. The result is registered, so a matching cycle produces one high clock on `matchPulse` in the following cycle. Counting and sequencing of matches, and any exception entry, are left to the logic around the block.

Top module: `xybrk_matcher`

## Requirements
- R1: With `cfgXyEn`=0, only internal-bus cycles (`ibValid`=1) can match. The address test is `((ibAddr ^ cfgAddrVal) & ~cfgAddrMask) == 0`, taken over all 32 bits. X and Y bus activity has no effect on `matchPulse`.
- R2: With `cfgXyEn`=1 and `cfgXySel`=0, only X-bus cycles (`xValid`=1) can match. `xAddr` is compared with `cfgAddrVal[31:16]` under `cfgAddrMask[31:16]`. Internal-bus and Y-bus activity has no effect.
- R3: With `cfgXyEn`=1 and `cfgXySel`=1, only Y-bus cycles (`yValid`=1) can match. `yAddr` is compared with `cfgAddrVal[15:0]` under `cfgAddrMask[15:0]`. Internal-bus and X-bus activity has no effect.
- R4: With `cfgDataCmpEn`=1, the data must also match under the data mask:
  - the internal bus uses `cfgDataVal`/`cfgDataMask` in full;
  - the X bus uses bits 31:16 of those registers;
  - the Y bus uses bits 15:0.
  With `cfgDataCmpEn`=0, the data value has no influence on the result.
- R5: A mask bit of 1 makes the corresponding address or data bit a don't-care. A mask bit of 0 requires equality.
- R6: Internal-bus qualifiers all use the same encoding: bit 0 and bit 1 each enable one choice, and 00 never matches.
  - `cfgMasterSel`: bit 0 allows the CPU (`ibMaster`=0) and bit 1 allows DMA (`ibMaster`=1).
  - `cfgKindSel`: bit 0 allows instruction fetch (`ibFetch`=1) and bit 1 allows data access (`ibFetch`=0).
  - `cfgDirSel`: bit 0 allows read (write=0) and bit 1 allows write (write=1).
  - `cfgSizeSel`: 00 means any size. Otherwise the value must equal `ibSize`, where 01 is byte, 10 is word and 11 is long.
- R7: An X/Y-bus cycle is a CPU data access. It qualifies only when all of the following hold:
  - `cfgMasterSel[0]`=1;
  - `cfgKindSel[1]`=1;
  - `cfgDirSel` allows that bus's write bit;
  - `cfgSizeSel` is 00 (any) or 10 (word).
  With `cfgSizeSel` at 01 or 11, X/Y mode never matches.
- R8: `matchPulse` is 0 after reset. For each qualifying, matching cycle it is high for exactly the one clock that follows that cycle, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgXyEn | input | 1 | 1: watch an X/Y bus; 0: watch the internal bus |
| cfgXySel | input | 1 | In X/Y mode: 0 selects X, 1 selects Y |
| cfgDataCmpEn | input | 1 | Enables the data compare |
| cfgMasterSel | input | 2 | Allowed masters (bit0 CPU, bit1 DMA) |
| cfgKindSel | input | 2 | Allowed kinds (bit0 fetch, bit1 data) |
| cfgDirSel | input | 2 | Allowed directions (bit0 read, bit1 write) |
| cfgSizeSel | input | 2 | 00 any, 01 byte, 10 word, 11 long |
| cfgAddrVal | input | 32 | Address compare value (X half 31:16, Y half 15:0) |
| cfgAddrMask | input | 32 | Address mask, 1 = ignore bit |
| cfgDataVal | input | 32 | Data compare value (X half 31:16, Y half 15:0) |
| cfgDataMask | input | 32 | Data mask, 1 = ignore bit |
| ibValid | input | 1 | Internal-bus cycle completes this clock |
| ibAddr | input | 32 | Internal-bus address |
| ibData | input | 32 | Internal-bus data |
| ibWrite | input | 1 | Internal-bus direction, 1 = write |
| ibMaster | input | 1 | Internal-bus master, 0 = CPU, 1 = DMA |
| ibFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| ibSize | input | 2 | Internal-bus operand size (01 byte, 10 word, 11 long) |
| xValid | input | 1 | X-bus cycle completes this clock |
| xAddr | input | 16 | X-bus address |
| xData | input | 16 | X-bus data |
| xWrite | input | 1 | X-bus direction, 1 = write |
| yValid | input | 1 | Y-bus cycle completes this clock |
| yAddr | input | 16 | Y-bus address |
| yData | input | 16 | Y-bus data |
| yWrite | input | 1 | Y-bus direction, 1 = write |
| matchPulse | output | 1 | One-clock break match, registered |

## Verification
A wrong lane selection or a wrong register-half split shows at the port as a pulse on the wrong bus, a pulse against the wrong half, or a missing pulse. Because the output has a single register stage, any such fault appears in the very next clock after the offending bus cycle. A broken qualifier or mask term shows in the same way: a pulse that should be absent, or a missing one, exactly one clock after the cycle. A faulty output register shows as a pulse that lasts longer than one clock or appears without a preceding cycle, and it is visible in the first idle clock after a match.

// File: rtl/xybrk_pkg.sv
package xybrk_pkg;

  localparam logic [1:0] SIZE_ANY  = 2'b00;
  localparam logic [1:0] SIZE_BYTE = 2'b01;
  localparam logic [1:0] SIZE_WORD = 2'b10;
  localparam logic [1:0] SIZE_LONG = 2'b11;

  // Strobes from the control part to the compare datapath.
  typedef struct packed {
    logic cycleValid;  // a candidate cycle on the chosen source
    logic qualOk;      // master/kind/direction/size qualifiers pass
    logic useXy;       // compare against an X/Y lane
    logic laneY;       // in X/Y mode: 1 = Y lane, 0 = X lane
    logic dataCmpEn;   // include the data compare
  } brkStrobe_t;

endpackage

// File: rtl/xybrk_ctrl.sv
module xybrk_ctrl
  import xybrk_pkg::*;
(
  input  logic       cfgXyEn,
  input  logic       cfgXySel,
  input  logic       cfgDataCmpEn,
  input  logic [1:0] cfgMasterSel,
  input  logic [1:0] cfgKindSel,
  input  logic [1:0] cfgDirSel,
  input  logic [1:0] cfgSizeSel,
  input  logic       ibValid,
  input  logic       ibWrite,
  input  logic       ibMaster,
  input  logic       ibFetch,
  input  logic [1:0] ibSize,
  input  logic       xValid,
  input  logic       xWrite,
  input  logic       yValid,
  input  logic       yWrite,
  output brkStrobe_t strobe
);

  logic ibQual;
  logic xyQual;
  logic laneValid;
  logic laneWrite;

  // Internal-bus qualifiers.
  always_comb begin
    logic masterOk;
    logic kindOk;
    logic dirOk;
    logic sizeOk;
    masterOk = ibMaster ? cfgMasterSel[1] : cfgMasterSel[0];
    kindOk   = ibFetch  ? cfgKindSel[0]   : cfgKindSel[1];
    dirOk    = ibWrite  ? cfgDirSel[1]    : cfgDirSel[0];
    sizeOk   = (cfgSizeSel == SIZE_ANY) || (cfgSizeSel == ibSize);
    ibQual   = masterOk & kindOk & dirOk & sizeOk;
  end

  // X/Y lane choice and qualifiers: the lane is always a CPU data word access.
  always_comb begin
    logic dirOk;
    logic sizeOk;
    laneValid = cfgXySel ? yValid : xValid;
    laneWrite = cfgXySel ? yWrite : xWrite;
    dirOk     = laneWrite ? cfgDirSel[1] : cfgDirSel[0];
    sizeOk    = (cfgSizeSel == SIZE_ANY) || (cfgSizeSel == SIZE_WORD);
    xyQual    = cfgMasterSel[0] & cfgKindSel[1] & dirOk & sizeOk;
  end

  always_comb begin
    strobe.useXy      = cfgXyEn;
    strobe.laneY      = cfgXySel;
    strobe.dataCmpEn  = cfgDataCmpEn;
    strobe.cycleValid = cfgXyEn ? laneValid : ibValid;
    strobe.qualOk     = cfgXyEn ? xyQual : ibQual;
  end

endmodule

// File: rtl/xybrk_dp.sv
module xybrk_dp
  import xybrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  brkStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgAddrVal,
  input  logic [ADDR_W-1:0] cfgAddrMask,
  input  logic [DATA_W-1:0] cfgDataVal,
  input  logic [DATA_W-1:0] cfgDataMask,
  input  logic [ADDR_W-1:0] ibAddr,
  input  logic [DATA_W-1:0] ibData,
  input  logic [ADDR_W/2-1:0] xAddr,
  input  logic [DATA_W/2-1:0] xData,
  input  logic [ADDR_W/2-1:0] yAddr,
  input  logic [DATA_W/2-1:0] yData,
  output logic              matchPulse
);

  localparam int AH = ADDR_W / 2;
  localparam int DH = DATA_W / 2;
  localparam int LANES = 2;  // lane 0 = Y (low half), lane 1 = X (high half)

  logic [LANES-1:0][AH-1:0] laneAddr;
  logic [LANES-1:0][DH-1:0] laneData;
  logic [LANES-1:0]         laneAddrHit;
  logic [LANES-1:0]         laneDataHit;
  logic                     ibAddrHit;
  logic                     ibDataHit;
  logic                     addrHit;
  logic                     dataHit;
  logic                     hitNow;

  assign laneAddr[0] = yAddr;
  assign laneAddr[1] = xAddr;
  assign laneData[0] = yData;
  assign laneData[1] = xData;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneAddrHit[g] =
      ((laneAddr[g] ^ cfgAddrVal[g*AH +: AH]) & ~cfgAddrMask[g*AH +: AH]) == '0;
    assign laneDataHit[g] =
      ((laneData[g] ^ cfgDataVal[g*DH +: DH]) & ~cfgDataMask[g*DH +: DH]) == '0;
  end

  assign ibAddrHit = ((ibAddr ^ cfgAddrVal) & ~cfgAddrMask) == '0;
  assign ibDataHit = ((ibData ^ cfgDataVal) & ~cfgDataMask) == '0;

  always_comb begin
    if (strobe.useXy) begin
      addrHit = strobe.laneY ? laneAddrHit[0] : laneAddrHit[1];
      dataHit = strobe.laneY ? laneDataHit[0] : laneDataHit[1];
    end else begin
      addrHit = ibAddrHit;
      dataHit = ibDataHit;
    end
    hitNow = strobe.cycleValid & strobe.qualOk & addrHit &
             (dataHit | ~strobe.dataCmpEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPulse <= 1'b0;
    else       matchPulse <= hitNow;
  end

endmodule

// File: rtl/xybrk_matcher.sv
module xybrk_matcher
  import xybrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgXyEn,
  input  logic                cfgXySel,
  input  logic                cfgDataCmpEn,
  input  logic [1:0]          cfgMasterSel,
  input  logic [1:0]          cfgKindSel,
  input  logic [1:0]          cfgDirSel,
  input  logic [1:0]          cfgSizeSel,
  input  logic [ADDR_W-1:0]   cfgAddrVal,
  input  logic [ADDR_W-1:0]   cfgAddrMask,
  input  logic [DATA_W-1:0]   cfgDataVal,
  input  logic [DATA_W-1:0]   cfgDataMask,
  input  logic                ibValid,
  input  logic [ADDR_W-1:0]   ibAddr,
  input  logic [DATA_W-1:0]   ibData,
  input  logic                ibWrite,
  input  logic                ibMaster,
  input  logic                ibFetch,
  input  logic [1:0]          ibSize,
  input  logic                xValid,
  input  logic [ADDR_W/2-1:0] xAddr,
  input  logic [DATA_W/2-1:0] xData,
  input  logic                xWrite,
  input  logic                yValid,
  input  logic [ADDR_W/2-1:0] yAddr,
  input  logic [DATA_W/2-1:0] yData,
  input  logic                yWrite,
  output logic                matchPulse
);

  brkStrobe_t strobe;

  xybrk_ctrl u_ctrl (
    .cfgXyEn      (cfgXyEn),
    .cfgXySel     (cfgXySel),
    .cfgDataCmpEn (cfgDataCmpEn),
    .cfgMasterSel (cfgMasterSel),
    .cfgKindSel   (cfgKindSel),
    .cfgDirSel    (cfgDirSel),
    .cfgSizeSel   (cfgSizeSel),
    .ibValid      (ibValid),
    .ibWrite      (ibWrite),
    .ibMaster     (ibMaster),
    .ibFetch      (ibFetch),
    .ibSize       (ibSize),
    .xValid       (xValid),
    .xWrite       (xWrite),
    .yValid       (yValid),
    .yWrite       (yWrite),
    .strobe       (strobe)
  );

  xybrk_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgAddrVal  (cfgAddrVal),
    .cfgAddrMask (cfgAddrMask),
    .cfgDataVal  (cfgDataVal),
    .cfgDataMask (cfgDataMask),
    .ibAddr      (ibAddr),
    .ibData      (ibData),
    .xAddr       (xAddr),
    .xData       (xData),
    .yAddr       (yAddr),
    .yData       (yData),
    .matchPulse  (matchPulse)
  );

endmodule

// File: rtl/xybrk_checker.sv
module xybrk_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgXyEn,
  input logic                cfgXySel,
  input logic                cfgDataCmpEn,
  input logic [1:0]          cfgMasterSel,
  input logic [1:0]          cfgSizeSel,
  input logic [ADDR_W-1:0]   cfgAddrVal,
  input logic [ADDR_W-1:0]   cfgAddrMask,
  input logic [DATA_W-1:0]   cfgDataVal,
  input logic [DATA_W-1:0]   cfgDataMask,
  input logic                ibValid,
  input logic [ADDR_W-1:0]   ibAddr,
  input logic [DATA_W-1:0]   ibData,
  input logic                xValid,
  input logic [ADDR_W/2-1:0] xAddr,
  input logic [DATA_W/2-1:0] xData,
  input logic                yValid,
  input logic [ADDR_W/2-1:0] yAddr,
  input logic                matchPulse
);

  localparam int AH = ADDR_W / 2;
  localparam int DH = DATA_W / 2;

  // R8: a pulse always follows a completed cycle on some bus
  a_r8_pulse_follows_cycle: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(ibValid | xValid | yValid));

  // R1: internal-bus mode only reacts to internal-bus cycles
  a_r1_ib_source: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !$past(cfgXyEn)) |-> $past(ibValid));

  // R2: X selection only reacts to X cycles
  a_r2_x_source: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(cfgXyEn) && !$past(cfgXySel)) |-> $past(xValid));

  // R3: Y selection only reacts to Y cycles, against the low register half
  a_r3_y_addr_low_half: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(cfgXyEn) && $past(cfgXySel)) |->
      ($past(yValid) &&
       (($past(yAddr) ^ $past(cfgAddrVal[AH-1:0])) & ~$past(cfgAddrMask[AH-1:0])) == '0));

  // R5: an internal-bus pulse implies equality on every unmasked address bit
  a_r5_ib_addr_masked: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !$past(cfgXyEn)) |->
      (($past(ibAddr) ^ $past(cfgAddrVal)) & ~$past(cfgAddrMask)) == '0);

  // R4: X data compare uses the upper register half
  a_r4_x_data_high_half: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(cfgXyEn) && !$past(cfgXySel) && $past(cfgDataCmpEn)) |->
      (($past(xData) ^ $past(cfgDataVal[DATA_W-1 -: DH])) &
       ~$past(cfgDataMask[DATA_W-1 -: DH])) == '0);

  // R4: internal-bus data compare uses the full registers
  a_r4_ib_data_full: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !$past(cfgXyEn) && $past(cfgDataCmpEn)) |->
      (($past(ibData) ^ $past(cfgDataVal)) & ~$past(cfgDataMask)) == '0);

  // R7: X/Y matches require CPU master allowed and word or unspecified size
  a_r7_xy_qualifier: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(cfgXyEn)) |->
      ($past(cfgMasterSel[0]) && ($past(cfgSizeSel) == 2'b00 || $past(cfgSizeSel) == 2'b10)));

  // R2: X address checked against upper register half
  a_r2_x_addr_high_half: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(cfgXyEn) && !$past(cfgXySel)) |->
      (($past(xAddr) ^ $past(cfgAddrVal[ADDR_W-1 -: AH])) &
       ~$past(cfgAddrMask[ADDR_W-1 -: AH])) == '0);

endmodule

bind xybrk_matcher xybrk_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgXyEn      (cfgXyEn),
  .cfgXySel     (cfgXySel),
  .cfgDataCmpEn (cfgDataCmpEn),
  .cfgMasterSel (cfgMasterSel),
  .cfgSizeSel   (cfgSizeSel),
  .cfgAddrVal   (cfgAddrVal),
  .cfgAddrMask  (cfgAddrMask),
  .cfgDataVal   (cfgDataVal),
  .cfgDataMask  (cfgDataMask),
  .ibValid      (ibValid),
  .ibAddr       (ibAddr),
  .ibData       (ibData),
  .xValid       (xValid),
  .xAddr        (xAddr),
  .xData        (xData),
  .yValid       (yValid),
  .yAddr        (yAddr),
  .matchPulse   (matchPulse)
);

// File: tb/xybrk_matcher_bench.sv
`timescale 1ns/1ps
module xybrk_matcher_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgXyEn = 0, cfgXySel = 0, cfgDataCmpEn = 0;
  logic [1:0]  cfgMasterSel = 0, cfgKindSel = 0, cfgDirSel = 0, cfgSizeSel = 0;
  logic [31:0] cfgAddrVal = 0, cfgAddrMask = 0, cfgDataVal = 0, cfgDataMask = 0;
  logic        ibValid = 0, ibWrite = 0, ibMaster = 0, ibFetch = 0;
  logic [31:0] ibAddr = 0, ibData = 0;
  logic [1:0]  ibSize = 0;
  logic        xValid = 0, xWrite = 0, yValid = 0, yWrite = 0;
  logic [15:0] xAddr = 0, xData = 0, yAddr = 0, yData = 0;
  logic        matchPulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xybrk_matcher u_xybrk_matcher (
    .clk(clk), .rstN(rstN),
    .cfgXyEn(cfgXyEn), .cfgXySel(cfgXySel), .cfgDataCmpEn(cfgDataCmpEn),
    .cfgMasterSel(cfgMasterSel), .cfgKindSel(cfgKindSel),
    .cfgDirSel(cfgDirSel), .cfgSizeSel(cfgSizeSel),
    .cfgAddrVal(cfgAddrVal), .cfgAddrMask(cfgAddrMask),
    .cfgDataVal(cfgDataVal), .cfgDataMask(cfgDataMask),
    .ibValid(ibValid), .ibAddr(ibAddr), .ibData(ibData), .ibWrite(ibWrite),
    .ibMaster(ibMaster), .ibFetch(ibFetch), .ibSize(ibSize),
    .xValid(xValid), .xAddr(xAddr), .xData(xData), .xWrite(xWrite),
    .yValid(yValid), .yAddr(yAddr), .yData(yData), .yWrite(yWrite),
    .matchPulse(matchPulse)
  );

  function automatic bit maskedEq32(input logic [31:0] a, input logic [31:0] b,
                                    input logic [31:0] m);
    for (int i = 0; i < 32; i++)
      if (!m[i] && (a[i] !== b[i])) return 0;
    return 1;
  endfunction

  // Reference model built from the requirements.
  function automatic bit expectMatch();
    bit dirAllowed;
    if (!cfgXyEn) begin                                   // R1, R6
      if (!ibValid) return 0;
      if (ibMaster == 1'b0 && !cfgMasterSel[0]) return 0;
      if (ibMaster == 1'b1 && !cfgMasterSel[1]) return 0;
      if (ibFetch && !cfgKindSel[0]) return 0;
      if (!ibFetch && !cfgKindSel[1]) return 0;
      dirAllowed = ibWrite ? cfgDirSel[1] : cfgDirSel[0];
      if (!dirAllowed) return 0;
      if (cfgSizeSel != 2'b00 && cfgSizeSel != ibSize) return 0;
      if (!maskedEq32(ibAddr, cfgAddrVal, cfgAddrMask)) return 0;
      if (cfgDataCmpEn && !maskedEq32(ibData, cfgDataVal, cfgDataMask)) return 0;
      return 1;
    end
    if (!cfgMasterSel[0] || !cfgKindSel[1]) return 0;     // R7
    if (!(cfgSizeSel == 2'b00 || cfgSizeSel == 2'b10)) return 0;
    if (!cfgXySel) begin                                  // R2
      if (!xValid) return 0;
      dirAllowed = xWrite ? cfgDirSel[1] : cfgDirSel[0];
      if (!dirAllowed) return 0;
      if (!maskedEq32({xAddr, 16'h0}, cfgAddrVal, cfgAddrMask | 32'h0000_FFFF)) return 0;
      if (cfgDataCmpEn &&
          !maskedEq32({xData, 16'h0}, cfgDataVal, cfgDataMask | 32'h0000_FFFF)) return 0;
    end else begin                                        // R3
      if (!yValid) return 0;
      dirAllowed = yWrite ? cfgDirSel[1] : cfgDirSel[0];
      if (!dirAllowed) return 0;
      if (!maskedEq32({16'h0, yAddr}, cfgAddrVal, cfgAddrMask | 32'hFFFF_0000)) return 0;
      if (cfgDataCmpEn &&
          !maskedEq32({16'h0, yData}, cfgDataVal, cfgDataMask | 32'hFFFF_0000)) return 0;
    end
    return 1;
  endfunction

  task automatic checkVal(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: matchPulse actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs are set at a negedge; the result is sampled one full clock later.
  task automatic step(input string req);
    bit exp;
    exp = expectMatch();
    @(negedge clk);
    checkVal(req, matchPulse, exp);
  endtask

  task automatic idleBuses();
    ibValid = 0; xValid = 0; yValid = 0;
  endtask

  task automatic openQualifiers();
    cfgMasterSel = 2'b11; cfgKindSel = 2'b11; cfgDirSel = 2'b11; cfgSizeSel = 2'b00;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    int seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    checkVal("R8 reset", matchPulse, 1'b0);
    rstN = 1;
    @(negedge clk);
    checkVal("R8 after reset", matchPulse, 1'b0);

    // R1: internal bus exact match, then X/Y activity ignored
    openQualifiers();
    cfgAddrVal = 32'hA5A5_1234; cfgAddrMask = 0;
    ibAddr = 32'hA5A5_1234; ibValid = 1; ibSize = 2'b11;
    step("R1 ib match");
    idleBuses();
    step("R8 single pulse");
    xValid = 1; xAddr = 16'hA5A5; yValid = 1; yAddr = 16'h1234;
    step("R1 xy ignored in ib mode");
    idleBuses();

    // R5: masked bit differs, still matches; unmasked differs, no match
    cfgAddrMask = 32'h0000_0010; ibAddr = 32'hA5A5_1224; ibValid = 1;
    step("R5 masked bit don't-care");
    ibAddr = 32'hA5A5_1230;
    step("R5 unmasked bit differs");
    idleBuses();

    // R2: X lane uses upper half; Y and ib ignored
    cfgXyEn = 1; cfgXySel = 0; cfgAddrMask = 0;
    cfgAddrVal = 32'h4321_8765;
    xValid = 1; xAddr = 16'h4321;
    step("R2 x upper half match");
    xAddr = 16'h8765;
    step("R2 x lower half no match");
    xValid = 0; yValid = 1; yAddr = 16'h8765; ibValid = 1; ibAddr = 32'h4321_8765;
    step("R2 y and ib ignored");
    idleBuses();

    // R3: Y lane uses lower half
    cfgXySel = 1; yValid = 1; yAddr = 16'h8765;
    step("R3 y lower half match");
    yValid = 0; xValid = 1; xAddr = 16'h4321;
    step("R3 x ignored");
    idleBuses();

    // R4: data compare on Y low half, then disabled
    cfgDataCmpEn = 1; cfgDataVal = 32'hBEEF_CAFE; cfgDataMask = 0;
    yValid = 1; yData = 16'hCAFE;
    step("R4 y data low half match");
    yData = 16'hBEEF;
    step("R4 y data mismatch");
    cfgDataCmpEn = 0;
    step("R4 data ignored when disabled");
    cfgXySel = 0; cfgDataCmpEn = 1; yValid = 0; xValid = 1; xData = 16'hBEEF;
    step("R4 x data high half match");
    idleBuses();

    // R7: size long/byte block X/Y; word allowed; master/kind constraints
    xValid = 1; cfgSizeSel = 2'b11;
    step("R7 long size blocked");
    cfgSizeSel = 2'b01;
    step("R7 byte size blocked");
    cfgSizeSel = 2'b10;
    step("R7 word size allowed");
    cfgMasterSel = 2'b10;
    step("R7 cpu not allowed");
    cfgMasterSel = 2'b11; cfgKindSel = 2'b01;
    step("R7 data kind not allowed");
    cfgKindSel = 2'b11; cfgDirSel = 2'b01; xWrite = 1;
    step("R7 write blocked");
    idleBuses(); xWrite = 0;

    // R6: internal-bus qualifiers
    cfgXyEn = 0; cfgDataCmpEn = 0; openQualifiers();
    cfgAddrMask = 32'hFFFF_FFFF; ibValid = 1; ibSize = 2'b01;
    cfgSizeSel = 2'b10;
    step("R6 size mismatch");
    cfgSizeSel = 2'b01;
    step("R6 size equal");
    ibMaster = 1; cfgMasterSel = 2'b01;
    step("R6 dma blocked");
    cfgMasterSel = 2'b10;
    step("R6 dma allowed");
    ibFetch = 1; cfgKindSel = 2'b10;
    step("R6 fetch blocked");
    cfgKindSel = 2'b01;
    step("R6 fetch allowed");
    idleBuses();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cfgXyEn = r[0]; cfgXySel = r[1]; cfgDataCmpEn = r[2];
      cfgMasterSel = (r[5:3] == 0) ? r[7:6] : 2'b11;
      cfgKindSel   = (r[10:8] == 0) ? r[12:11] : 2'b11;
      cfgDirSel    = (r[15:13] == 0) ? r[17:16] : 2'b11;
      cfgSizeSel   = r[19:18];
      cfgAddrVal = $urandom; cfgDataVal = $urandom;
      cfgAddrMask = $urandom & $urandom & $urandom;
      cfgDataMask = $urandom & $urandom & $urandom;
      ibValid = r[20]; xValid = r[21]; yValid = r[22];
      ibWrite = r[23]; xWrite = r[24]; yWrite = r[25];
      ibMaster = r[26] & r[27]; ibFetch = r[28] & r[29]; ibSize = r[31:30];
      ibAddr = $urandom; ibData = $urandom;
      if (($urandom % 4) != 0) begin
        ibAddr = cfgAddrVal ^ (cfgAddrMask & $urandom);
        ibData = cfgDataVal ^ (($urandom % 2) ? (cfgDataMask & $urandom) : $urandom);
      end
      xAddr = ($urandom % 4 != 0) ? cfgAddrVal[31:16] : 16'($urandom);
      yAddr = ($urandom % 4 != 0) ? cfgAddrVal[15:0]  : 16'($urandom);
      xData = ($urandom % 2 != 0) ? cfgDataVal[31:16] : 16'($urandom);
      yData = ($urandom % 2 != 0) ? cfgDataVal[15:0]  : 16'($urandom);
      step(cfgXyEn ? (cfgXySel ? "R3 random" : "R2 random") : "R1 random");
    end

    done = 1;
    summary();
  end

endmodule